// File: doc/BRIEF.md
# Queued SPI Master Engine

This block is a SPI master that works through a queue of up to sixteen single-byte transfers. Software does nothing between bytes. Software first fills three storage areas through a simple word-addressed register bus: transmit bytes, receive bytes and per-entry command words. It then programs a start index and an end index and sets the run bit. The engine walks the queue from the start index to the end index. For each entry it shifts one byte out on MOSI, most significant bit first, and captures MISO into the receive storage. It drives chip select low or high as the command word of each entry says.

When the last entry has shifted, the engine clears the run bit and sets a finished flag. Chip select can be held low in three ways: between entries, after the last entry, or across several separate runs. This lets software build one long SPI transaction out of queue-sized pieces. A lock bit holds chip select low across a chain of runs. Writing 0 to the lock while the engine is idle closes the transaction.

Register map (byte data, 8-bit word address):

| Address | Contents |
|---|---|
| 0x00+2i | TX byte of entry i (odd addresses read 0, writes dropped) |
| 0x20+2i+1 | RX byte of entry i (read only, even addresses read 0) |
| 0x40+i | command of entry i (bit 0 = hold chip select) |
| 0x50 | start index |
| 0x51 | end index |
| 0x52 | control (bit 0 run, bit 1 hold after queue) |
| 0x53 | status (bit 0 finished, bits 7:4 current index) |
| 0x54 | lock (bit 0) |
| 0x55 | SCK half-period in clock cycles |

Top module: `spiq_engine`

## Requirements
- R1: A run executes entries from the start index (0x50) up to and including the end index (0x51), stepping by one and wrapping from 15 to 0.
- R2: Entry i transmits the byte stored at address 2i, most significant bit first on MOSI. The first bit is on MOSI when chip select falls, and MOSI is 0 while no byte is shifting.
- R3: The byte received for entry i is readable at address 0x20+2i+1, in the low 8 bits.
- R4: SPI mode 0: SCK idles low and is high only while chip select is low. MISO is sampled on the rising edge and MOSI changes only on the falling edge. Each SCK half period lasts the number of clock cycles in register 0x55 (reset value 8; a value of 0 acts as 1).
- R5: Writing control bit 0 = 1 while idle starts a run. Chip select falls two cycles after the write edge. The engine clears bit 0 in the same cycle it sets the finished flag.
- R6: Writing status with bit 0 = 0 clears the finished flag. If that write lands in the cycle the engine sets the flag, the flag ends up set.
- R7: When the command bit 0 of an entry is 1 and the entry is not the last, chip select stays low and the next byte starts with no gap. When the bit is 0, chip select goes high for one SCK half period before the next entry.
- R8: After the last entry, chip select stays low if that entry's command bit 0, control bit 1 or the lock bit is 1. The next run then continues with chip select still low.
- R9: Writing 0 to the lock register while idle drives chip select high on the next cycle.
- R10: While a run is active, writes to TX, command, index, control and divider registers are dropped.
- R11: Status bits 7:4 give the current entry index. After a run they equal the end index.
- R12: After reset chip select is high, SCK and MOSI are low, control and status read 0, and the divider reads 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_wr | input | 1 | write strobe for one cycle |
| bus_addr | input | 8 | word address for read and write |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data, combinational from bus_addr |
| spi_sck | output | 1 | serial clock |
| spi_mosi | output | 1 | serial data out |
| spi_miso | input | 1 | serial data in |
| spi_cs_n | output | 1 | active-low chip select |

## Verification
Two functions can meet in one clock edge: the engine setting the finished flag at the end of a run, and a software write to status that clears it. The bench counts the exact number of edges from the start write to the final decision edge of a run with no gaps. It then lands the clearing write on that edge and expects the flag to read 1. A second run lands the same write one edge later and expects 0. A write to the start index dropped in the end cycle of a run is judged the same way, by reading the index back.

// File: rtl/spiq_pkg.sv
package spiq_pkg;

    localparam int ADDRW = 8;
    localparam int DATAW = 8;

    localparam logic [ADDRW-1:0] ADR_RX   = 8'h20;
    localparam logic [ADDRW-1:0] ADR_CMD  = 8'h40;
    localparam logic [ADDRW-1:0] ADR_SPTR = 8'h50;
    localparam logic [ADDRW-1:0] ADR_EPTR = 8'h51;
    localparam logic [ADDRW-1:0] ADR_CTRL = 8'h52;
    localparam logic [ADDRW-1:0] ADR_STAT = 8'h53;
    localparam logic [ADDRW-1:0] ADR_LOCK = 8'h54;
    localparam logic [ADDRW-1:0] ADR_DIV  = 8'h55;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_GAP
    } seq_state_e;

endpackage

// File: rtl/spiq_shifter.sv
module spiq_shifter #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [7:0]      byte_i,
    input  logic [DIVW-1:0] div_i,
    input  logic            miso_i,
    output logic            sck_o,
    output logic            mosi_o,
    output logic            done_o,
    output logic [7:0]      byte_o
);

    typedef struct packed {
        logic            busy;
        logic            sck;
        logic            samp;
        logic            done;
        logic [2:0]      nbit;
        logic [DIVW-1:0] cnt;
        logic [7:0]      sr;
    } shf_t;

    shf_t q, d;
    logic [DIVW-1:0] lim;

    always_comb begin
        lim    = (div_i == '0) ? DIVW'(1) : div_i;
        d      = q;
        d.done = 1'b0;
        if (start_i) begin
            d.busy = 1'b1;
            d.sck  = 1'b0;
            d.cnt  = '0;
            d.nbit = '0;
            d.sr   = byte_i;
        end else if (q.busy) begin
            if (q.cnt == lim - 1'b1) begin
                d.cnt = '0;
                if (!q.sck) begin
                    d.sck  = 1'b1;
                    d.samp = miso_i;
                end else begin
                    d.sck  = 1'b0;
                    d.sr   = {q.sr[6:0], q.samp};
                    d.nbit = q.nbit + 1'b1;
                    if (q.nbit == 3'd7) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck_o  = q.sck;
    assign mosi_o = q.busy & q.sr[7];
    assign done_o = q.done;
    assign byte_o = q.sr;

endmodule

// File: rtl/spiq_regs.sv
module spiq_regs
    import spiq_pkg::*;
#(
    parameter int QDEPTH    = 16,
    parameter int DIVW      = 8,
    parameter int DIV_RESET = 8,
    localparam int IDXW     = $clog2(QDEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [ADDRW-1:0] bus_addr,
    input  logic [DATAW-1:0] bus_wdata,
    output logic [DATAW-1:0] bus_rdata,
    input  logic             rx_we_i,
    input  logic [IDXW-1:0]  cur_idx_i,
    input  logic [7:0]       rx_byte_i,
    input  logic             end_ev_i,
    output logic             run_o,
    output logic             keep_o,
    output logic             lock_o,
    output logic             done_o,
    output logic             lock_rel_o,
    output logic [IDXW-1:0]  sptr_o,
    output logic [IDXW-1:0]  eptr_o,
    output logic [DIVW-1:0]  div_o,
    output logic [7:0]       tx_byte_o,
    output logic             cmd_hold_o
);

    typedef struct packed {
        logic [QDEPTH-1:0][7:0] tx;
        logic [QDEPTH-1:0][7:0] rx;
        logic [QDEPTH-1:0]      cmd;
        logic [IDXW-1:0]        sptr;
        logic [IDXW-1:0]        eptr;
        logic                   run;
        logic                   keep;
        logic                   done;
        logic                   lock;
        logic [DIVW-1:0]        div;
    } regs_t;

    regs_t q, d;
    logic  wr_idle;

    always_comb begin
        d       = q;
        wr_idle = bus_wr && !q.run;
        if (wr_idle) begin
            if (bus_addr < ADR_RX) begin
                if (!bus_addr[0]) d.tx[bus_addr[IDXW:1]] = bus_wdata;
            end else if (bus_addr >= ADR_CMD && bus_addr < ADR_SPTR) begin
                d.cmd[bus_addr[IDXW-1:0]] = bus_wdata[0];
            end else begin
                case (bus_addr)
                    ADR_SPTR: d.sptr = bus_wdata[IDXW-1:0];
                    ADR_EPTR: d.eptr = bus_wdata[IDXW-1:0];
                    ADR_DIV:  d.div  = bus_wdata[DIVW-1:0];
                    ADR_CTRL: begin
                        d.keep = bus_wdata[1];
                        if (bus_wdata[0]) d.run = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
        if (bus_wr && bus_addr == ADR_STAT && !bus_wdata[0]) d.done = 1'b0;
        if (bus_wr && bus_addr == ADR_LOCK) d.lock = bus_wdata[0];
        if (rx_we_i) d.rx[cur_idx_i] = rx_byte_i;
        if (end_ev_i) begin
            d.run  = 1'b0;
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.div <= DIVW'(DIV_RESET);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADR_RX) begin
            if (!bus_addr[0]) bus_rdata = q.tx[bus_addr[IDXW:1]];
        end else if (bus_addr < ADR_CMD) begin
            if (bus_addr[0]) bus_rdata = q.rx[bus_addr[IDXW:1]];
        end else if (bus_addr < ADR_SPTR) begin
            bus_rdata[0] = q.cmd[bus_addr[IDXW-1:0]];
        end else begin
            case (bus_addr)
                ADR_SPTR: bus_rdata[IDXW-1:0] = q.sptr;
                ADR_EPTR: bus_rdata[IDXW-1:0] = q.eptr;
                ADR_CTRL: bus_rdata[1:0]      = {q.keep, q.run};
                ADR_STAT: begin
                    bus_rdata[0]         = q.done;
                    bus_rdata[4 +: IDXW] = cur_idx_i;
                end
                ADR_LOCK: bus_rdata[0]           = q.lock;
                ADR_DIV:  bus_rdata[DIVW-1:0]    = q.div;
                default:  bus_rdata              = '0;
            endcase
        end
    end

    assign run_o      = q.run;
    assign keep_o     = q.keep;
    assign lock_o     = q.lock;
    assign done_o     = q.done;
    assign sptr_o     = q.sptr;
    assign eptr_o     = q.eptr;
    assign div_o      = q.div;
    assign tx_byte_o  = q.tx[cur_idx_i];
    assign cmd_hold_o = q.cmd[cur_idx_i];
    assign lock_rel_o = bus_wr && bus_addr == ADR_LOCK && !bus_wdata[0] && !q.run;

endmodule

// File: rtl/spiq_seq.sv
module spiq_seq
    import spiq_pkg::*;
#(
    parameter int QDEPTH = 16,
    parameter int DIVW   = 8,
    localparam int IDXW  = $clog2(QDEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            keep_i,
    input  logic            lock_i,
    input  logic            lock_rel_i,
    input  logic [IDXW-1:0] sptr_i,
    input  logic [IDXW-1:0] eptr_i,
    input  logic [DIVW-1:0] div_i,
    input  logic            cmd_hold_i,
    input  logic            sh_done_i,
    output logic            sh_start_o,
    output logic            rx_we_o,
    output logic            end_ev_o,
    output logic [IDXW-1:0] cur_idx_o,
    output logic            cs_n_o
);

    typedef struct packed {
        seq_state_e      state;
        logic [IDXW-1:0] idx;
        logic            cs_n;
        logic [DIVW-1:0] gcnt;
    } seq_t;

    seq_t q, d;
    logic last, hold;
    logic [DIVW-1:0] lim;

    always_comb begin
        d          = q;
        sh_start_o = 1'b0;
        rx_we_o    = 1'b0;
        end_ev_o   = 1'b0;
        lim        = (div_i == '0) ? DIVW'(1) : div_i;
        last       = (q.idx == eptr_i);
        hold       = cmd_hold_i | (last & (keep_i | lock_i));
        case (q.state)
            ST_IDLE: begin
                if (run_i) begin
                    d.idx   = sptr_i;
                    d.state = ST_LOAD;
                end else if (lock_rel_i) begin
                    d.cs_n = 1'b1;
                end
            end
            ST_LOAD: begin
                sh_start_o = 1'b1;
                d.cs_n     = 1'b0;
                d.state    = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (sh_done_i) begin
                    rx_we_o = 1'b1;
                    if (!hold) d.cs_n = 1'b1;
                    if (last) begin
                        end_ev_o = 1'b1;
                        d.state  = ST_IDLE;
                    end else begin
                        d.idx   = q.idx + 1'b1;
                        d.gcnt  = '0;
                        d.state = hold ? ST_LOAD : ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (q.gcnt == lim - 1'b1) d.state = ST_LOAD;
                else                      d.gcnt  = q.gcnt + 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.idx   <= '0;
            q.cs_n  <= 1'b1;
            q.gcnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign cur_idx_o = q.idx;
    assign cs_n_o    = q.cs_n;

endmodule

// File: rtl/spiq_engine.sv
module spiq_engine
    import spiq_pkg::*;
#(
    parameter int QDEPTH    = 16,
    parameter int DIVW      = 8,
    parameter int DIV_RESET = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [ADDRW-1:0] bus_addr,
    input  logic [DATAW-1:0] bus_wdata,
    output logic [DATAW-1:0] bus_rdata,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n
);

    localparam int IDXW = $clog2(QDEPTH);

    logic            run_w, keep_w, lock_w, done_w, lock_rel_w;
    logic [IDXW-1:0] sptr_w, eptr_w, idx_w;
    logic [DIVW-1:0] div_w;
    logic [7:0]      tx_byte_w, rx_byte_w;
    logic            cmd_hold_w, sh_start_w, sh_done_w, rx_we_w, end_ev_w;

    spiq_regs #(.QDEPTH(QDEPTH), .DIVW(DIVW), .DIV_RESET(DIV_RESET)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .rx_we_i    (rx_we_w),
        .cur_idx_i  (idx_w),
        .rx_byte_i  (rx_byte_w),
        .end_ev_i   (end_ev_w),
        .run_o      (run_w),
        .keep_o     (keep_w),
        .lock_o     (lock_w),
        .done_o     (done_w),
        .lock_rel_o (lock_rel_w),
        .sptr_o     (sptr_w),
        .eptr_o     (eptr_w),
        .div_o      (div_w),
        .tx_byte_o  (tx_byte_w),
        .cmd_hold_o (cmd_hold_w)
    );

    spiq_seq #(.QDEPTH(QDEPTH), .DIVW(DIVW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_w),
        .keep_i     (keep_w),
        .lock_i     (lock_w),
        .lock_rel_i (lock_rel_w),
        .sptr_i     (sptr_w),
        .eptr_i     (eptr_w),
        .div_i      (div_w),
        .cmd_hold_i (cmd_hold_w),
        .sh_done_i  (sh_done_w),
        .sh_start_o (sh_start_w),
        .rx_we_o    (rx_we_w),
        .end_ev_o   (end_ev_w),
        .cur_idx_o  (idx_w),
        .cs_n_o     (spi_cs_n)
    );

    spiq_shifter #(.DIVW(DIVW)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sh_start_w),
        .byte_i  (tx_byte_w),
        .div_i   (div_w),
        .miso_i  (spi_miso),
        .sck_o   (spi_sck),
        .mosi_o  (spi_mosi),
        .done_o  (sh_done_w),
        .byte_o  (rx_byte_w)
    );

endmodule

// File: rtl/spiq_chk.sv
module spiq_chk
    import spiq_pkg::*;
#(
    parameter int IDXW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [ADDRW-1:0] bus_addr,
    input logic [DATAW-1:0] bus_wdata,
    input logic             spi_sck,
    input logic             spi_mosi,
    input logic             spi_cs_n,
    input logic             run,
    input logic             done,
    input logic [IDXW-1:0]  sptr
);

    // R4: serial clock pulses only inside a chip-select window
    p_sck_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n);

    // R4: data out holds while the serial clock stays high
    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    // R5: finished flag rises together with the run bit falling
    p_done_with_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(run));

    // R10: start index unchanged by a write during a run
    p_ptr_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bus_wr && bus_addr == ADR_SPTR) |=> $stable(sptr));

    // R9: clearing the lock while idle releases chip select
    p_cs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_LOCK && !bus_wdata[0] && !run) |=> spi_cs_n);

endmodule

bind spiq_engine spiq_chk #(.IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n),
    .run       (run_w),
    .done      (done_w),
    .sptr      (sptr_w)
);

// File: tb/sim_spiq_engine.sv
module sim_spiq_engine;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_sck, spi_mosi, spi_cs_n;
    logic       flip = 1'b0;
    logic       spi_miso;

    assign spi_miso = spi_mosi ^ flip;

    spiq_engine u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // reference state
    logic [7:0] m_tx [16];
    logic [7:0] m_rx [16];
    bit         m_cmd [16];
    int         m_sptr = 0, m_eptr = 0, m_div = 8;
    bit         m_keep = 0, m_lock = 0, run_busy = 0;
    logic       exp_cs = 1'b1, exp_sck = 1'b0, exp_mosi = 1'b0;

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_tx[i] = '0; m_rx[i] = '0; m_cmd[i] = 0;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic play();
        int  i  = m_sptr;
        int  dv = (m_div == 0) ? 1 : m_div;
        bit  last, hold;
        logic [7:0] b;
        @(posedge clk);
        forever begin
            @(posedge clk);
            exp_cs = 1'b0; exp_sck = 1'b0; b = m_tx[i]; exp_mosi = b[7];
            for (int k = 0; k < 8; k++) begin
                repeat (dv) @(posedge clk);
                exp_sck = 1'b1;
                repeat (dv) @(posedge clk);
                exp_sck = 1'b0;
                exp_mosi = (k < 7) ? b[6-k] : 1'b0;
            end
            @(posedge clk);
            m_rx[i] = b ^ {8{flip}};
            last = (i == m_eptr);
            hold = m_cmd[i] || (last && (m_keep || m_lock));
            if (!hold) exp_cs = 1'b1;
            if (last) break;
            i = (i + 1) % 16;
            if (!hold) repeat (dv) @(posedge clk);
        end
        #1 run_busy = 0;
    endtask

    // behavioural view of the register writes (R10: dropped while a run is active)
    always @(posedge clk) begin
        if (rst_n && bus_wr) begin
            if (!run_busy) begin
                if (bus_addr < 8'h20) begin
                    if (!bus_addr[0]) m_tx[bus_addr[4:1]] = bus_wdata;
                end else if (bus_addr >= 8'h40 && bus_addr < 8'h50) begin
                    m_cmd[bus_addr[3:0]] = bus_wdata[0];
                end else if (bus_addr == 8'h50) m_sptr = bus_wdata[3:0];
                else if (bus_addr == 8'h51) m_eptr = bus_wdata[3:0];
                else if (bus_addr == 8'h55) m_div = bus_wdata;
                else if (bus_addr == 8'h52) begin
                    m_keep = bus_wdata[1];
                    if (bus_wdata[0]) begin
                        run_busy = 1;
                        fork play(); join_none
                    end
                end
            end
            if (bus_addr == 8'h54) begin
                m_lock = bus_wdata[0];
                if (!bus_wdata[0] && !run_busy) exp_cs = 1'b1;   // R9
            end
        end
    end

    // per-cycle pin comparison (R2, R4, R7, R8)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(spi_cs_n, exp_cs, "R7 R8 cs_n pin");
            chk(spi_sck, exp_sck, "R4 sck pin");
            chk(spi_mosi, exp_mosi, "R2 mosi pin");
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_run();
        while (run_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_up();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [7:0] v;
        int n, dv, edges;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        rd(8'h52, v); chk(v, 8'h00, "R12 control after reset");
        rd(8'h53, v); chk(v, 8'h00, "R12 status after reset");
        rd(8'h55, v); chk(v, 8'h08, "R12 divider after reset");
        chk(spi_cs_n, 1'b1, "R12 cs_n after reset");

        // R1 R2 R3 R5: basic four-entry run, chip select released between bytes
        wr(8'h00, 8'hA5); wr(8'h02, 8'h3C); wr(8'h04, 8'h81); wr(8'h06, 8'h7E);
        wr(8'h01, 8'hFF);
        rd(8'h01, v); chk(v, 8'h00, "R2 odd TX slot unused");
        wr(8'h55, 8'd2); wr(8'h50, 8'd0); wr(8'h51, 8'd3);
        wr(8'h52, 8'h01);
        rd(8'h52, v); chk(v[0], 1'b1, "R5 run bit set while active");
        wait_run();
        for (int i = 0; i < 4; i++) begin
            rd(8'(8'h21 + 2*i), v); chk(v, m_rx[i], "R3 received byte");
        end
        rd(8'h20, v); chk(v, 8'h00, "R3 even RX slot reads zero");
        rd(8'h52, v); chk(v[0], 1'b0, "R5 run bit cleared at end");
        rd(8'h53, v); chk(v, 8'h31, "R11 R5 status idx and finished");
        wr(8'h53, 8'h00);
        rd(8'h53, v); chk(v[0], 1'b0, "R6 finished cleared by write");

        // R7: held chip select with divider 1 and inverted echo
        flip = 1'b1;
        wr(8'h0A, 8'h12); wr(8'h0C, 8'hF0); wr(8'h0E, 8'h55); wr(8'h10, 8'hC3);
        wr(8'h45, 8'h01); wr(8'h46, 8'h01); wr(8'h47, 8'h00);
        wr(8'h55, 8'd1); wr(8'h50, 8'd5); wr(8'h51, 8'd8);
        wr(8'h52, 8'h01);
        wait_run();
        for (int i = 5; i < 9; i++) begin
            rd(8'(8'h21 + 2*i), v); chk(v, m_rx[i], "R7 R3 received byte held run");
        end

        // R1 R11: wrap from 15 to 0, divider 0 acts as 1
        flip = 1'b0;
        wr(8'h1C, 8'h9A); wr(8'h1E, 8'h46);
        wr(8'h55, 8'd0); wr(8'h50, 8'd14); wr(8'h51, 8'd1);
        wr(8'h52, 8'h01);
        wait_run();
        rd(8'h3D, v); chk(v, m_rx[14], "R1 wrap entry 14");
        rd(8'h3F, v); chk(v, m_rx[15], "R1 wrap entry 15");
        rd(8'h21, v); chk(v, m_rx[0], "R1 wrap entry 0");
        rd(8'h23, v); chk(v, m_rx[1], "R1 wrap entry 1");
        rd(8'h53, v); chk(v[7:4], 4'd1, "R11 index equals end index");

        // R8: hold after queue, then chained run, then R9 lock release
        wr(8'h55, 8'd3); wr(8'h50, 8'd2); wr(8'h51, 8'd2);
        wr(8'h52, 8'h03);
        wait_run();
        chk(spi_cs_n, 1'b0, "R8 cs held after queue by control bit");
        wr(8'h52, 8'h01);
        wait_run();
        chk(spi_cs_n, 1'b1, "R8 cs released when nothing holds");
        wr(8'h54, 8'h01);
        wr(8'h52, 8'h01);
        wait_run();
        chk(spi_cs_n, 1'b0, "R8 cs held by lock");
        wr(8'h52, 8'h01);
        wait_run();
        chk(spi_cs_n, 1'b0, "R8 chained run keeps cs low");
        wr(8'h54, 8'h00);
        chk(spi_cs_n, 1'b1, "R9 lock clear releases cs");

        // R10: writes during a run are dropped
        wr(8'h55, 8'd8); wr(8'h50, 8'd0); wr(8'h51, 8'd3);
        wr(8'h52, 8'h01);
        repeat (20) @(negedge clk);
        wr(8'h00, 8'h11); wr(8'h50, 8'd9); wr(8'h55, 8'd1); wr(8'h40, 8'h01);
        wait_run();
        rd(8'h00, v); chk(v, 8'hA5, "R10 TX write dropped");
        rd(8'h50, v); chk(v, 8'h00, "R10 start index write dropped");
        rd(8'h55, v); chk(v, 8'h08, "R10 divider write dropped");
        rd(8'h40, v); chk(v, 8'h00, "R10 command write dropped");

        // R6: status clear lands on the finishing edge (set wins), then one edge later
        n = 3; dv = 1;
        wr(8'h55, 8'(dv)); wr(8'h50, 8'd0); wr(8'h51, 8'd2);
        wr(8'h40, 8'h01); wr(8'h41, 8'h01); wr(8'h42, 8'h00);
        edges = n * (2 + 16*dv) + 1;
        wr(8'h52, 8'h01);
        repeat (edges - 1) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h53; bus_wdata = 8'h00;
        @(negedge clk);
        bus_wr = 1'b0;
        wait_run();
        rd(8'h53, v); chk(v[0], 1'b1, "R6 set wins over same-cycle clear");
        wr(8'h52, 8'h01);
        repeat (edges) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h53; bus_wdata = 8'h00;
        @(negedge clk);
        bus_wr = 1'b0;
        wait_run();
        rd(8'h53, v); chk(v[0], 1'b0, "R6 clear one cycle after finish");

        // R10: start index write on the finishing edge is dropped
        wr(8'h52, 8'h01);
        repeat (edges - 1) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h50; bus_wdata = 8'd7;
        @(negedge clk);
        bus_wr = 1'b0;
        wait_run();
        rd(8'h50, v); chk(v, 8'h00, "R10 index write in final cycle dropped");

        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule